// File: doc/BRIEF.md
# DMA Channel Transfer Termination Controller

This block sequences one DMA channel. It accepts transfer requests, moves one data unit per request as a read beat followed by a write beat on a ready/valid bus master port, counts the units that remain and decides when the channel stops. A request line can be sensed by rising edge or by level. The channel runs in one of two modes. In cycle-steal mode it gives up the bus after every read/write pair. In burst mode it keeps the bus from one pair to the next.

A channel stops in one of two ways. When the remaining count reaches zero, it raises a sticky end flag and, if interrupts are enabled, an interrupt level. When software drops the enable bit, it stops without setting the flag. In both cases a pair that has already started always finishes before the channel goes quiet. The flag also blocks any new start until software clears it.

Top module: `dma_term_ctrl`

## Requirements
- R1: The remaining count (`remain`) falls by exactly one when each write beat completes and changes in no other way except by a load. No transfer starts while `remain` is 0, including after a zero count is loaded with the enable set and the request active.
- R2: Each transfer is a read beat (`bus_write`=0) at the source address followed by a write beat (`bus_write`=1) at the destination address that carries the read data. Both addresses advance by `ADDR_STEP` after each pair. While `bus_valid` is 1 and `bus_ready` is 0, the beat's address and direction stay unchanged.
- R3: Once a read beat has completed, the next beat is the paired write, even if enable was cleared during the read.
- R4: When the write that brings `remain` to 0 completes, `xfer_end` becomes 1 in the same clock edge. It stays 1 until a `flag_clear` pulse. If a set and a clear fall in the same cycle, the set wins.
- R5: `irq` is 1 exactly while `xfer_end` and `cfg_irq_en` are both 1.
- R6: Clearing `cfg_enable` stops the channel after the pair in progress. `xfer_end` stays 0 and `irq` stays 0.
- R7: While `xfer_end` is 1, no transfer starts, even with the enable set, a nonzero count and an active request. After `flag_clear`, transfers resume.
- R8: In cycle-steal mode (`cfg_burst`=0), `bus_valid` drops after every write beat and the request is sampled again. With edge sensing (`cfg_level`=0), each rising edge of `dreq` seen while the channel is armed yields one transfer. With level sensing (`cfg_level`=1), `dreq`=1 at a sample point yields one transfer.
- R9: In burst mode with edge sensing, a single rising edge starts a run of back-to-back pairs with the bus held. The run continues until the count is exhausted or the enable is cleared.
- R10: In burst mode with level sensing, the bus is held while `dreq` is 1 at each pair boundary. If `dreq` is 0 at a boundary, the bus is released and `xfer_end` stays 0.
- R11: `cnt_load` takes the count and both addresses only while `bus_valid` is 0. A load during a transfer is ignored.
- R12: After reset, `bus_valid`, `xfer_end`, `irq` and `remain` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Software channel enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_burst | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| cfg_level | input | 1 | 1 = level-sensed request, 0 = rising-edge sensed |
| cnt_load | input | 1 | Load count and addresses (honoured only when idle) |
| cnt_value | input | CW | Count to load |
| src_value | input | AW | Source start address to load |
| dst_value | input | AW | Destination start address to load |
| flag_clear | input | 1 | Pulse that clears the end flag |
| dreq | input | 1 | Transfer request line |
| bus_valid | output | 1 | Beat request; also marks the bus as held |
| bus_write | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, taken when the read beat completes |
| bus_ready | input | 1 | Beat completes on a clock edge where valid and ready are both 1 |
| remain | output | CW | Transfers still to do |
| xfer_end | output | 1 | Sticky count-exhausted flag |
| irq | output | 1 | Interrupt level |

## Verification
The assertions check, on every cycle, the rules that are local in time. A completed read is always followed by a write. A stalled beat holds its address. The count moves only on a write or a load. The end flag rises only on the write that empties the count. No pair starts while the channel is disabled, flagged or empty. Cycle-steal mode releases the bus after each write. Properties cannot express the run-level outcomes, so only the bench scenarios show them: the total number of pairs, the address and data sequence, edge-versus-level request counting, the quiet stop after the enable is dropped, and the resume after the flag is cleared.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/dma_term_req.sv
// Request sensing: level pass-through or latched rising edge.
module dma_term_req (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic level_mode,
  input  logic armed,
  input  logic take,
  output logic req_hit
);
  logic dreq_q, dreq_q_n;
  logic edge_pend, edge_pend_n;
  logic rise;

  always_comb begin
    rise        = dreq & ~dreq_q;
    dreq_q_n    = dreq;
    edge_pend_n = armed & (rise | (edge_pend & ~take));
    req_hit     = level_mode ? dreq : edge_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q    <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      dreq_q    <= dreq_q_n;
      edge_pend <= edge_pend_n;
    end
  end
endmodule

// File: rtl/dma_term_path.sv
// Count, address and data registers of the channel.
module dma_term_path #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int ADDR_STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_cnt,
  input  logic [AW-1:0] load_src,
  input  logic [AW-1:0] load_dst,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_done,
  output logic [CW-1:0] remain,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] hold_data,
  output logic          cnt_zero,
  output logic          cnt_last
);
  localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] remain_n;
  logic [AW-1:0] src_n, dst_n;
  logic [DW-1:0] data_n;
  logic          cnt_en, addr_en, data_en;

  always_comb begin
    cnt_en   = load_en | wr_done;
    addr_en  = load_en | wr_done;
    data_en  = rd_done;
    remain_n = load_en ? load_cnt : (remain - ONE);
    src_n    = load_en ? load_src : (src_addr + STEP);
    dst_n    = load_en ? load_dst : (dst_addr + STEP);
    data_n   = rd_data;
    cnt_zero = (remain == '0);
    cnt_last = (remain == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      src_addr  <= '0;
      dst_addr  <= '0;
      hold_data <= '0;
    end else begin
      if (cnt_en)  remain    <= remain_n;
      if (addr_en) begin
        src_addr <= src_n;
        dst_addr <= dst_n;
      end
      if (data_en) hold_data <= data_n;
    end
  end
endmodule

// File: rtl/dma_term_seq.sv
// Beat sequencer, end flag and stop rules.
module dma_term_seq
  import dma_term_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        burst,
  input  logic        level,
  input  logic        dreq,
  input  logic        req_hit,
  input  logic        cnt_zero,
  input  logic        cnt_last,
  input  logic        bus_ready,
  input  logic        flag_clear,
  output xfer_state_t state,
  output logic        armed,
  output logic        take,
  output logic        rd_done,
  output logic        wr_done,
  output logic        flag
);
  xfer_state_t state_n;
  logic        run_q, run_n;
  logic        flag_n, flag_set;
  logic        go_on;

  always_comb begin
    state_n  = state;
    run_n    = run_q;
    take     = 1'b0;
    rd_done  = 1'b0;
    wr_done  = 1'b0;
    flag_set = 1'b0;
    armed    = enable & ~flag;
    go_on    = burst & enable & ~cnt_last & (level ? dreq : run_q);
    unique case (state)
      ST_IDLE: begin
        if (armed && !cnt_zero && req_hit) begin
          state_n = ST_READ;
          take    = 1'b1;
          run_n   = burst & ~level;
        end
      end
      ST_READ: begin
        if (bus_ready) begin
          rd_done = 1'b1;
          state_n = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (bus_ready) begin
          wr_done  = 1'b1;
          flag_set = cnt_last;
          if (go_on) begin
            state_n = ST_READ;
            take    = 1'b1;
          end else begin
            state_n = ST_IDLE;
            run_n   = 1'b0;
          end
        end
      end
      default: begin
        state_n = ST_IDLE;
        run_n   = 1'b0;
      end
    endcase
    flag_n = flag_set | (flag & ~flag_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      run_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      state <= state_n;
      run_q <= run_n;
      flag  <= flag_n;
    end
  end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int ADDR_STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_irq_en,
  input  logic          cfg_burst,
  input  logic          cfg_level,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_value,
  input  logic [AW-1:0] src_value,
  input  logic [AW-1:0] dst_value,
  input  logic          flag_clear,
  input  logic          dreq,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic [CW-1:0] remain,
  output logic          xfer_end,
  output logic          irq
);
  xfer_state_t   state;
  logic          armed, take, rd_done, wr_done, flag;
  logic          req_hit, cnt_zero, cnt_last, load_en;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] hold_data;

  always_comb begin
    load_en   = cnt_load & (state == ST_IDLE);
    bus_valid = (state != ST_IDLE);
    bus_write = (state == ST_WRITE);
    bus_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
    bus_wdata = hold_data;
    xfer_end  = flag;
    irq       = flag & cfg_irq_en;
  end

  dma_term_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .level_mode (cfg_level),
    .armed      (armed),
    .take       (take),
    .req_hit    (req_hit)
  );

  dma_term_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .burst      (cfg_burst),
    .level      (cfg_level),
    .dreq       (dreq),
    .req_hit    (req_hit),
    .cnt_zero   (cnt_zero),
    .cnt_last   (cnt_last),
    .bus_ready  (bus_ready),
    .flag_clear (flag_clear),
    .state      (state),
    .armed      (armed),
    .take       (take),
    .rd_done    (rd_done),
    .wr_done    (wr_done),
    .flag       (flag)
  );

  dma_term_path #(
    .AW        (AW),
    .DW        (DW),
    .CW        (CW),
    .ADDR_STEP (ADDR_STEP)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_cnt  (cnt_value),
    .load_src  (src_value),
    .load_dst  (dst_value),
    .rd_done   (rd_done),
    .rd_data   (bus_rdata),
    .wr_done   (wr_done),
    .remain    (remain),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .hold_data (hold_data),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );
endmodule

// File: rtl/dma_term_checker.sv
module dma_term_checker #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          cfg_burst,
  input logic          cnt_load,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [CW-1:0] remain,
  input logic          xfer_end,
  input logic          irq
);
  logic rd_hs, wr_hs;
  always_comb begin
    rd_hs = bus_valid & ~bus_write & bus_ready;
    wr_hs = bus_valid & bus_write & bus_ready;
  end

  assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs |=> (bus_valid && bus_write));

  assert_beat_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

  assert_count_moves_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != $past(remain)) |-> $past(cnt_load || wr_hs));

  assert_end_only_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_end) |-> (remain == '0 && $past(wr_hs)));

  assert_no_start_when_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(cfg_enable && !xfer_end && remain != '0));

  assert_steal_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && !cfg_burst) |=> !bus_valid);

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> xfer_end);
endmodule

bind dma_term_ctrl dma_term_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .cfg_burst  (cfg_burst),
  .cnt_load   (cnt_load),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_ready  (bus_ready),
  .bus_addr   (bus_addr),
  .remain     (remain),
  .xfer_end   (xfer_end),
  .irq        (irq)
);

// File: tb/dma_term_ctrl_test.sv
module dma_term_ctrl_test;
  localparam int AW = 16, DW = 16, CW = 8, STEP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_enable = 1'b0, cfg_irq_en = 1'b0, cfg_burst = 1'b0, cfg_level = 1'b0;
  logic          cnt_load = 1'b0, flag_clear = 1'b0, dreq = 1'b0;
  logic [CW-1:0] cnt_value = '0;
  logic [AW-1:0] src_value = '0, dst_value = '0;
  logic          bus_valid, bus_write, bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic [CW-1:0] remain;
  logic          xfer_end, irq;

  dma_term_ctrl #(.AW(AW), .DW(DW), .CW(CW), .ADDR_STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_irq_en(cfg_irq_en),
    .cfg_burst(cfg_burst), .cfg_level(cfg_level), .cnt_load(cnt_load),
    .cnt_value(cnt_value), .src_value(src_value), .dst_value(dst_value),
    .flag_clear(flag_clear), .dreq(dreq), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .remain(remain), .xfer_end(xfer_end), .irq(irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int rd_cnt = 0, wr_cnt = 0, hold_rises = 0, mism = 0;
  bit stall = 1'b0, hold_prev = 1'b0, done = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return DW'(a ^ 16'h5A3C);
  endfunction

  function automatic logic [AW-1:0] nth_addr(input logic [AW-1:0] base, input int i);
    return base + AW'(i * STEP);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Bus responder and monitor: decisions at the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (bus_valid && !hold_prev) hold_rises++;
    hold_prev = bus_valid;
    bus_ready <= 1'b0;
    if (bus_valid && !bus_write) bus_rdata <= mem_f(bus_addr);
    if (bus_valid && !stall && ($urandom % 4 != 0)) begin
      bus_ready <= 1'b1;
      if (!bus_write) begin
        if (bus_addr != nth_addr(src_base, wr_cnt)) mism++;
        rd_cnt++;
      end else begin
        if (bus_addr != nth_addr(dst_base, wr_cnt)) mism++;
        if (bus_wdata != mem_f(nth_addr(src_base, wr_cnt))) mism++;
        wr_cnt++;
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_flag();
    flag_clear = 1'b1; tick(); flag_clear = 1'b0;
  endtask

  task automatic setup(input int n, input bit burst, input bit level, input bit ie);
    cfg_burst = burst; cfg_level = level; cfg_irq_en = ie;
    cnt_value = CW'(n);
    src_value = AW'($urandom % 1024) * 2;
    dst_value = 16'h8000 + AW'($urandom % 1024) * 2;
    cnt_load = 1'b1; tick(); cnt_load = 1'b0;
    src_base = src_value; dst_base = dst_value;
    rd_cnt = 0; wr_cnt = 0; hold_rises = 0; mism = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 3000 && quiet < 10; i++) begin
      tick();
      quiet = bus_valid ? 0 : quiet + 1;
    end
  endtask

  task automatic wait_writes(input int k);
    for (int i = 0; i < 3000 && wr_cnt < k; i++) tick();
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    // R12: reset state
    check(!bus_valid && !xfer_end && !irq && remain == 0, "R12 reset state",
          int'({bus_valid, xfer_end, irq}) + int'(remain), 0);
    rst_n = 1'b1;
    tick(2);

    // R1: zero count loaded, enable and request active -> nothing happens
    setup(0, 1'b0, 1'b1, 1'b1);
    cfg_enable = 1'b1; dreq = 1'b1;
    tick(40);
    check(rd_cnt == 0 && !xfer_end, "R1 zero count no transfer", rd_cnt, 0);
    dreq = 1'b0; cfg_enable = 1'b0; tick(2);

    // R8: cycle-steal, edge sensed: one pair per rising edge
    setup(5, 1'b0, 1'b0, 1'b1);
    cfg_enable = 1'b1;
    for (int p = 0; p < 3; p++) begin
      dreq = 1'b1; tick(); dreq = 1'b0; tick(30);
    end
    check(wr_cnt == 3, "R8 cycle-steal edge pair count", wr_cnt, 3);
    check(remain == 2 && !xfer_end, "R8 remaining after edges", int'(remain), 2);
    check(hold_rises == 3, "R8 bus released between pairs", hold_rises, 3);
    for (int p = 0; p < 2; p++) begin
      dreq = 1'b1; tick(); dreq = 1'b0; tick(30);
    end
    // R4/R5: exhaustion sets flag and irq
    check(xfer_end == 1'b1 && remain == 0, "R4 flag at count zero", int'(xfer_end), 1);
    check(irq == 1'b1, "R5 irq with enable", int'(irq), 1);
    check(mism == 0, "R2 address and data sequence", mism, 0);

    // R7: flag blocks a new start; R11 load accepted while idle
    setup(3, 1'b0, 1'b1, 1'b0);
    check(remain == 3, "R11 load while idle", int'(remain), 3);
    check(irq == 1'b0 && xfer_end, "R5 irq masked", int'(irq), 0);
    cfg_irq_en = 1'b1; tick();
    check(irq == 1'b1, "R5 irq follows enable", int'(irq), 1);
    cfg_irq_en = 1'b0;
    dreq = 1'b1; tick(40);
    check(rd_cnt == 0, "R7 no start while flag set", rd_cnt, 0);
    clear_flag();
    // R4: flag clear drops it
    check(xfer_end == 1'b0, "R4 flag cleared", int'(xfer_end), 0);
    wait_idle();
    check(wr_cnt == 3 && xfer_end, "R7 resume after clear", wr_cnt, 3);
    dreq = 1'b0; clear_flag();

    // R10: burst level, dreq dropped mid-run
    setup(50, 1'b1, 1'b1, 1'b1);
    dreq = 1'b1;
    wait_writes(3);
    dreq = 1'b0;
    wait_idle();
    check(!xfer_end && wr_cnt < 50, "R10 burst level stops quietly", int'(xfer_end), 0);
    check(wr_cnt + int'(remain) == 50, "R1 count tracks writes", wr_cnt + int'(remain), 50);
    check(hold_rises == 1, "R10 bus held through burst", hold_rises, 1);

    // R9 + R6: burst edge, stopped by enable drop
    setup(50, 1'b1, 1'b0, 1'b1);
    dreq = 1'b1; tick(); dreq = 1'b0;
    wait_writes(4);
    cfg_enable = 1'b0;
    wait_idle();
    check(wr_cnt >= 4 && wr_cnt < 50 && wr_cnt == rd_cnt, "R9 burst edge ran until enable drop", wr_cnt, 4);
    check(!xfer_end && !irq, "R6 quiet stop", int'({xfer_end, irq}), 0);
    check(wr_cnt + int'(remain) == 50, "R6 count consistent", wr_cnt + int'(remain), 50);
    check(hold_rises == 1, "R9 single bus hold", hold_rises, 1);

    // R3: enable cleared while read beat stalls
    setup(10, 1'b0, 1'b1, 1'b1);
    cfg_enable = 1'b1; dreq = 1'b1;
    for (int i = 0; i < 200 && !(bus_valid && !bus_write && wr_cnt >= 2); i++) tick();
    stall = 1'b1; cfg_enable = 1'b0; tick(3); stall = 1'b0;
    wait_idle();
    dreq = 1'b0;
    check(wr_cnt == rd_cnt && wr_cnt >= 3, "R3 write completes after read", wr_cnt, rd_cnt);
    check(!xfer_end && int'(remain) == 10 - wr_cnt, "R6 stop after pair", int'(remain), 10 - wr_cnt);

    // R11: load during a burst is ignored
    setup(20, 1'b1, 1'b0, 1'b0);
    cfg_enable = 1'b1;
    dreq = 1'b1; tick(); dreq = 1'b0;
    wait_writes(2);
    cnt_value = 8'd3; cnt_load = 1'b1; tick(); cnt_load = 1'b0;
    wait_idle();
    check(wr_cnt == 20 && xfer_end, "R11 busy load ignored", wr_cnt, 20);
    check(mism == 0, "R2 burst addresses", mism, 0);
    clear_flag();

    // Random runs with the request held until exhaustion
    for (int it = 0; it < 20; it++) begin
      int n = 1 + int'($urandom % 12);
      int md = int'($urandom % 3);
      bit ie = 1'($urandom);
      setup(n, md != 0, md != 1, ie);
      cfg_enable = 1'b1; dreq = 1'b1;
      if (md == 1) begin tick(); dreq = 1'b0; end
      wait_idle();
      dreq = 1'b0;
      check(wr_cnt == n && remain == 0, "R1 random run length", wr_cnt, n);
      check(xfer_end && irq == ie, "R4 random flag and R5 irq", int'(irq), int'(ie));
      check(mism == 0, "R2 random addresses", mism, 0);
      check(hold_rises == ((md == 0) ? n : 1), "R8 random bus holds", hold_rises, (md == 0) ? n : 1);
      clear_flag();
    end

    done = 1'b1;
    finish_run();
  end
endmodule